// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass Pair

This block moves single command words between two independently clocked ports without passing them through the data queue. Each port writes a mailbox that the other port reads. Port A fills mailbox 1 and drains mailbox 2. Port B fills mailbox 2 and drains mailbox 1. Each mailbox has an active-low "full" flag. The writing port owns this flag, and it falls when a word is accepted. The reading port sees a synchronized copy of the flag. A mailbox read that the reader makes while its copy shows full sends a clear event back to the writer across the clock boundary.

Each port also has a read-data selector. While that port's bus is driven, the selector presents either the queue's output word or the mailbox that the port reads. Command words do not flow as a stream here, so every pin is a plain control or data level and there is no valid/ready handshake. Back-pressure is the full flag itself: a write offered while the flag is low is dropped.

Top module: `dual_mailbox`

## Requirements
- R1: A write on a port stores that port's input word into its outgoing mailbox at the next rising edge of that port's clock, and the port's tx flag reads low after that edge. A write has chip select low, enable high, read/write select 1 and mailbox select 1.
- R2: A write offered while the port's tx flag is low is dropped. The stored word is unchanged, and the reader later receives the first word.
- R3: A port operation takes effect only when chip select is low and enable is high. A write with mailbox select 0 leaves the mailbox and its flag untouched. A mailbox read with chip select high or enable low does not clear the flag.
- R4: After the writer's tx flag falls, the reading port's rx flag falls within 4 reader clock cycles.
- R5: A mailbox read (read/write select 0, mailbox select 1) taken while the reader's rx flag is low raises that rx flag at the same reader edge. The writer's tx flag returns high within 8 writer clock cycles.
- R6: Reading a mailbox leaves its contents unchanged. Repeated reads return the same word until a new write is accepted.
- R7: A port's bus is driven (dout_oe = 1) exactly when its chip select is low and read/write select is 0. While driven, dout carries the incoming mailbox word if mailbox select is 1 and the queue word otherwise. While not driven, dout is all zeros.
- R8: While reset is active (rst_n low), and after its release, both mailboxes hold zero and all four flags read high.
- R9: Reads made while the reader's rx flag is high never clear a word written afterwards. Such a word stays flagged full until it is itself read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_en | input | 1 | Port A operation enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbx_sel | input | 1 | Port A target: 1 mailbox, 0 queue |
| a_din | input | W | Port A write word |
| a_q_word | input | W | Queue output word offered to port A |
| a_dout | output | W | Port A read word |
| a_dout_oe | output | 1 | Port A bus drive enable |
| a_tx_flag_n | output | 1 | Mailbox 1 full, low active, port A domain |
| a_rx_flag_n | output | 1 | Mailbox 2 full, low active, port A domain |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_en | input | 1 | Port B operation enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mbx_sel | input | 1 | Port B target: 1 mailbox, 0 queue |
| b_din | input | W | Port B write word |
| b_q_word | input | W | Queue output word offered to port B |
| b_dout | output | W | Port B read word |
| b_dout_oe | output | 1 | Port B bus drive enable |
| b_tx_flag_n | output | 1 | Mailbox 2 full, low active, port B domain |
| b_rx_flag_n | output | 1 | Mailbox 1 full, low active, port B domain |

## Verification
The assertions check the single-domain rules on every cycle. These are the flag drop after an accepted write, the frozen mailbox word while the flag is low, the inertness of a deselected port, the immediate rx release after a consuming read, and the idle bus being zero. The cross-domain behaviour can only be shown by the bench's scenarios, with the two clocks running at unrelated periods. That behaviour covers the rx flag following the tx flag within its window, the clear returning to the writer, the word surviving repeated reads, and the case where stale reads issued before a refill must not consume the new word.

// File: rtl/dmbx_pkg.sv
package dmbx_pkg;

  localparam int unsigned DEF_WIDTH = 36;
  localparam int unsigned DEF_SYNC  = 2;

  typedef struct packed {
    logic mbx_wr;
    logic mbx_rd;
    logic drive;
    logic use_mbx;
  } port_op_t;

  function automatic port_op_t decode_op(input logic cs_n, input logic en,
                                         input logic wr, input logic sel);
    port_op_t op;
    logic     picked;
    picked     = !cs_n && en;
    op.mbx_wr  = picked && wr && sel;
    op.mbx_rd  = picked && !wr && sel;
    op.drive   = !cs_n && !wr;
    op.use_mbx = sel;
    return op;
  endfunction

endpackage

// File: rtl/dmbx_sync.sv
module dmbx_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dmbx_port_dec.sv
module dmbx_port_dec import dmbx_pkg::*; #(
  parameter int unsigned W = DEF_WIDTH
) (
  input  logic         cs_n,
  input  logic         en,
  input  logic         wr,
  input  logic         sel,
  input  logic [W-1:0] q_word,
  input  logic [W-1:0] mbx_word,
  output port_op_t     op,
  output logic [W-1:0] dout,
  output logic         dout_oe
);
  always_comb begin
    op      = decode_op(cs_n, en, wr, sel);
    dout_oe = op.drive;
    if (!op.drive)      dout = '0;
    else if (op.use_mbx) dout = mbx_word;
    else                 dout = q_word;
  end
endmodule

// File: rtl/dmbx_channel.sv
module dmbx_channel import dmbx_pkg::*; #(
  parameter int unsigned W           = DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic         wr_clk,
  input  logic         wr_rst_n,
  input  logic         rd_clk,
  input  logic         rd_rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W-1:0] mbx_data,
  output logic         wr_flag_n,
  output logic         rd_flag_n
);
  localparam int unsigned ECHO_STAGES = SYNC_STAGES + 1;

  // writer domain
  logic         clr_tgl_w;
  logic         clr_seen;
  logic         clr_pulse;
  logic [W-1:0] word_q;
  logic         full_n_q;

  // reader domain
  logic clr_tgl_r;
  logic echo_r;
  logic pending_q;
  logic flag_seen_n;

  dmbx_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clr_sync (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(clr_tgl_r), .q(clr_tgl_w));

  assign clr_pulse = clr_tgl_w ^ clr_seen;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      word_q   <= '0;
      full_n_q <= 1'b1;
      clr_seen <= 1'b0;
    end else begin
      clr_seen <= clr_tgl_w;
      if (clr_pulse) begin
        full_n_q <= 1'b1;
      end else if (wr_req && full_n_q) begin
        full_n_q <= 1'b0;
        word_q   <= wr_data;
      end
    end
  end

  assign mbx_data  = word_q;
  assign wr_flag_n = full_n_q;

  dmbx_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_flag_sync (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(full_n_q), .q(flag_seen_n));

  dmbx_sync #(.W(1), .STAGES(ECHO_STAGES), .RST_VAL(1'b0)) u_echo_sync (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(clr_seen), .q(echo_r));

  assign rd_flag_n = flag_seen_n | pending_q;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      clr_tgl_r <= 1'b0;
      pending_q <= 1'b0;
    end else if (rd_req && !rd_flag_n) begin
      clr_tgl_r <= ~clr_tgl_r;
      pending_q <= 1'b1;
    end else if (pending_q && (echo_r == clr_tgl_r)) begin
      pending_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox import dmbx_pkg::*; #(
  parameter int unsigned W           = DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         a_cs_n,
  input  logic         a_en,
  input  logic         a_wr,
  input  logic         a_mbx_sel,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] a_q_word,
  output logic [W-1:0] a_dout,
  output logic         a_dout_oe,
  output logic         a_tx_flag_n,
  output logic         a_rx_flag_n,
  input  logic         b_cs_n,
  input  logic         b_en,
  input  logic         b_wr,
  input  logic         b_mbx_sel,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] b_q_word,
  output logic [W-1:0] b_dout,
  output logic         b_dout_oe,
  output logic         b_tx_flag_n,
  output logic         b_rx_flag_n
);
  localparam int unsigned NPORT = 2;

  logic         clk_v  [NPORT];
  logic         rst_ok [NPORT];
  logic         cs_v   [NPORT];
  logic         en_v   [NPORT];
  logic         wr_v   [NPORT];
  logic         sel_v  [NPORT];
  logic [W-1:0] din_v  [NPORT];
  logic [W-1:0] qw_v   [NPORT];
  logic [W-1:0] dout_v [NPORT];
  logic         oe_v   [NPORT];
  logic [W-1:0] mbx_v  [NPORT];
  logic         txf_v  [NPORT];
  logic         rxf_v  [NPORT];
  port_op_t     op_v   [NPORT];

  logic         rst_a_ok, rst_b_ok;
  logic [W-1:0] mbx1_word, mbx2_word;

  assign clk_v[0] = clk_a;     assign clk_v[1] = clk_b;
  assign cs_v[0]  = a_cs_n;    assign cs_v[1]  = b_cs_n;
  assign en_v[0]  = a_en;      assign en_v[1]  = b_en;
  assign wr_v[0]  = a_wr;      assign wr_v[1]  = b_wr;
  assign sel_v[0] = a_mbx_sel; assign sel_v[1] = b_mbx_sel;
  assign din_v[0] = a_din;     assign din_v[1] = b_din;
  assign qw_v[0]  = a_q_word;  assign qw_v[1]  = b_q_word;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      dmbx_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
        .clk(clk_v[p]), .rst_n(rst_n), .d(1'b1), .q(rst_ok[p]));

      dmbx_port_dec #(.W(W)) u_dec (
        .cs_n    (cs_v[p]),
        .en      (en_v[p]),
        .wr      (wr_v[p]),
        .sel     (sel_v[p]),
        .q_word  (qw_v[p]),
        .mbx_word(mbx_v[NPORT-1-p]),
        .op      (op_v[p]),
        .dout    (dout_v[p]),
        .dout_oe (oe_v[p]));

      // channel p carries words written by port p to the other port
      dmbx_channel #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
        .wr_clk   (clk_v[p]),
        .wr_rst_n (rst_ok[p]),
        .rd_clk   (clk_v[NPORT-1-p]),
        .rd_rst_n (rst_ok[NPORT-1-p]),
        .wr_req   (op_v[p].mbx_wr),
        .wr_data  (din_v[p]),
        .rd_req   (op_v[NPORT-1-p].mbx_rd),
        .mbx_data (mbx_v[p]),
        .wr_flag_n(txf_v[p]),
        .rd_flag_n(rxf_v[NPORT-1-p]));
    end
  endgenerate

  assign a_dout      = dout_v[0];
  assign a_dout_oe   = oe_v[0];
  assign a_tx_flag_n = txf_v[0];
  assign a_rx_flag_n = rxf_v[0];
  assign b_dout      = dout_v[1];
  assign b_dout_oe   = oe_v[1];
  assign b_tx_flag_n = txf_v[1];
  assign b_rx_flag_n = rxf_v[1];

  assign rst_a_ok  = rst_ok[0];
  assign rst_b_ok  = rst_ok[1];
  assign mbx1_word = mbx_v[0];
  assign mbx2_word = mbx_v[1];
endmodule

// File: rtl/dmbx_chk.sv
module dmbx_chk #(
  parameter int unsigned W = 36
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         a_ok,
  input logic         b_ok,
  input logic         a_cs_n,
  input logic         a_en,
  input logic         a_wr,
  input logic         a_mbx_sel,
  input logic [W-1:0] a_din,
  input logic [W-1:0] a_dout,
  input logic         a_dout_oe,
  input logic         a_tx_flag_n,
  input logic         b_cs_n,
  input logic         b_en,
  input logic         b_wr,
  input logic         b_mbx_sel,
  input logic [W-1:0] b_din,
  input logic [W-1:0] b_dout,
  input logic         b_dout_oe,
  input logic         b_tx_flag_n,
  input logic         b_rx_flag_n,
  input logic [W-1:0] mbx1_word,
  input logic [W-1:0] mbx2_word
);
  // R1
  a_store_chk: assert property (@(posedge clk_a) disable iff (!a_ok)
    (!a_cs_n && a_en && a_wr && a_mbx_sel && a_tx_flag_n)
      |=> (!a_tx_flag_n && mbx1_word == $past(a_din)));

  // R1
  b_store_chk: assert property (@(posedge clk_b) disable iff (!b_ok)
    (!b_cs_n && b_en && b_wr && b_mbx_sel && b_tx_flag_n)
      |=> (!b_tx_flag_n && mbx2_word == $past(b_din)));

  // R2
  a_full_hold_chk: assert property (@(posedge clk_a) disable iff (!a_ok)
    !a_tx_flag_n |=> $stable(mbx1_word));

  // R2
  b_full_hold_chk: assert property (@(posedge clk_b) disable iff (!b_ok)
    !b_tx_flag_n |=> $stable(mbx2_word));

  // R3
  a_deselect_chk: assert property (@(posedge clk_a) disable iff (!a_ok)
    (a_cs_n && a_tx_flag_n) |=> a_tx_flag_n);

  // R5
  b_rx_release_chk: assert property (@(posedge clk_b) disable iff (!b_ok)
    (!b_cs_n && b_en && !b_wr && b_mbx_sel && !b_rx_flag_n) |=> b_rx_flag_n);

  // R7
  a_idle_bus_chk: assert property (@(posedge clk_a) disable iff (!a_ok)
    !a_dout_oe |-> (a_dout == '0));

  // R7
  b_idle_bus_chk: assert property (@(posedge clk_b) disable iff (!b_ok)
    !b_dout_oe |-> (b_dout == '0));
endmodule

bind dual_mailbox dmbx_chk #(.W(W)) u_dmbx_chk (
  .clk_a(clk_a), .clk_b(clk_b), .a_ok(rst_a_ok), .b_ok(rst_b_ok),
  .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr), .a_mbx_sel(a_mbx_sel),
  .a_din(a_din), .a_dout(a_dout), .a_dout_oe(a_dout_oe), .a_tx_flag_n(a_tx_flag_n),
  .b_cs_n(b_cs_n), .b_en(b_en), .b_wr(b_wr), .b_mbx_sel(b_mbx_sel),
  .b_din(b_din), .b_dout(b_dout), .b_dout_oe(b_dout_oe), .b_tx_flag_n(b_tx_flag_n),
  .b_rx_flag_n(b_rx_flag_n), .mbx1_word(mbx1_word), .mbx2_word(mbx2_word));

// File: tb/dual_mailbox_bench.sv
`timescale 1ns/1ps
module dual_mailbox_bench;
  localparam int W = 36;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_cs_n = 1'b1, a_en = 1'b0, a_wr = 1'b0, a_mbx_sel = 1'b0;
  logic b_cs_n = 1'b1, b_en = 1'b0, b_wr = 1'b0, b_mbx_sel = 1'b0;
  logic [W-1:0] a_din = '0, a_q_word = '0, b_din = '0, b_q_word = '0;
  logic [W-1:0] a_dout, b_dout;
  logic a_dout_oe, b_dout_oe, a_tx_flag_n, a_rx_flag_n, b_tx_flag_n, b_rx_flag_n;

  dual_mailbox #(.W(W)) u_dual_mailbox (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr), .a_mbx_sel(a_mbx_sel),
    .a_din(a_din), .a_q_word(a_q_word), .a_dout(a_dout), .a_dout_oe(a_dout_oe),
    .a_tx_flag_n(a_tx_flag_n), .a_rx_flag_n(a_rx_flag_n),
    .b_cs_n(b_cs_n), .b_en(b_en), .b_wr(b_wr), .b_mbx_sel(b_mbx_sel),
    .b_din(b_din), .b_q_word(b_q_word), .b_dout(b_dout), .b_dout_oe(b_dout_oe),
    .b_tx_flag_n(b_tx_flag_n), .b_rx_flag_n(b_rx_flag_n));

  always #2.5  clk_a = ~clk_a;
  always #3.65 clk_b = ~clk_b;

  int n_cmp = 0, n_bad = 0;
  bit mon_on = 1'b0, done = 1'b0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_b = '0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor for mailbox 1 words seen on port B
  always @(negedge clk_b) begin
    if (mon_on && !b_cs_n && b_en && !b_wr && b_mbx_sel) begin
      if (!b_rx_flag_n) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 word delivered that was never accepted", b_dout, '0);
        else begin
          last_b = exp_q.pop_front();
          chk(b_dout == last_b, "R1 mailbox1 word at port B", b_dout, last_b);
        end
      end else if (a_tx_flag_n) begin
        chk(b_dout == last_b, "R6 word kept after read", b_dout, last_b);
      end
    end
  end

  task automatic a_set(input logic cs_n, en, wr, sel, input logic [W-1:0] d);
    @(posedge clk_a); #1;
    a_cs_n = cs_n; a_en = en; a_wr = wr; a_mbx_sel = sel; a_din = d;
  endtask
  task automatic b_set(input logic cs_n, en, wr, sel, input logic [W-1:0] d);
    @(posedge clk_b); #1;
    b_cs_n = cs_n; b_en = en; b_wr = wr; b_mbx_sel = sel; b_din = d;
  endtask

  // driver: offer a word to mailbox 1, push it when the flag says accepted
  task automatic a_put(input logic [W-1:0] w);
    a_set(1'b0, 1'b1, 1'b1, 1'b1, w);
    @(negedge clk_a);
    if (a_tx_flag_n) exp_q.push_back(w);
    a_set(1'b1, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic b_get();
    b_set(1'b0, 1'b1, 1'b0, 1'b1, '0);
    b_set(1'b1, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic wait_b_rx_low(input int limit, input string req);
    int n = 0;
    @(negedge clk_b);
    while (b_rx_flag_n && n < limit) begin n++; @(negedge clk_b); end
    chk(!b_rx_flag_n, req, {35'd0, b_rx_flag_n}, '0);
  endtask

  task automatic wait_a_tx_high(input int limit, input string req);
    int n = 0;
    @(negedge clk_a);
    while (!a_tx_flag_n && n < limit) begin n++; @(negedge clk_a); end
    chk(a_tx_flag_n, req, {35'd0, a_tx_flag_n}, 36'd1);
  endtask

  initial begin
    repeat (4) @(posedge clk_a);
    @(negedge clk_a);
    // R8: flags high while reset is held
    chk(a_tx_flag_n && a_rx_flag_n && b_tx_flag_n && b_rx_flag_n,
        "R8 flags during reset", {32'd0, a_tx_flag_n, a_rx_flag_n, b_tx_flag_n, b_rx_flag_n}, 36'hF);
    rst_n = 1'b1;
    repeat (6) @(posedge clk_b);
    @(negedge clk_a);
    chk(a_tx_flag_n && a_rx_flag_n && b_tx_flag_n && b_rx_flag_n,
        "R8 flags after reset", {32'd0, a_tx_flag_n, a_rx_flag_n, b_tx_flag_n, b_rx_flag_n}, 36'hF);
    mon_on = 1'b1;

    // R8 and R7: empty mailbox reads as zero, bus driven
    b_set(1'b0, 1'b1, 1'b0, 1'b1, '0);
    @(negedge clk_b);
    chk(b_dout_oe && b_dout == '0, "R8 reset mailbox content", b_dout, '0);
    b_set(1'b1, 1'b0, 1'b0, 1'b0, '0);

    // R1 then R4
    a_put(36'h1_2345_6789);
    @(negedge clk_a);
    chk(!a_tx_flag_n, "R1 tx flag low after write", {35'd0, a_tx_flag_n}, '0);
    wait_b_rx_low(4, "R4 rx flag follows tx flag");

    // R2: second write dropped while full
    a_put(36'hA_BCDE_F012);
    chk(exp_q.size() == 1, "R2 write to full mailbox dropped", exp_q.size(), 36'd1);

    // R5 and R6
    b_get();
    @(negedge clk_b);
    chk(b_rx_flag_n, "R5 rx flag high after read", {35'd0, b_rx_flag_n}, 36'd1);
    wait_a_tx_high(8, "R5 tx flag returns high");
    b_get();
    b_get();

    // accepted refill
    a_put(36'h5_5AA5_0FF0);
    wait_b_rx_low(6, "R4 rx flag follows refill");
    b_get();
    wait_a_tx_high(8, "R5 tx flag high after second read");

    // R3: deselected and queue-directed writes have no effect
    a_set(1'b1, 1'b1, 1'b1, 1'b1, 36'hF_FFFF_FFFF);
    a_set(1'b0, 1'b0, 1'b1, 1'b1, 36'hF_FFFF_FFFF);
    a_set(1'b0, 1'b1, 1'b1, 1'b0, 36'hF_FFFF_FFFF);
    a_set(1'b1, 1'b0, 1'b0, 1'b0, '0);
    @(negedge clk_a);
    chk(a_tx_flag_n, "R3 ignored writes leave flag high", {35'd0, a_tx_flag_n}, 36'd1);
    b_get();  // monitor: word still the previous one (R3, R6)

    // R3: deselected read does not clear
    a_put(36'h0_1357_9BDF);
    wait_b_rx_low(6, "R4 rx flag low for new word");
    b_set(1'b1, 1'b1, 1'b0, 1'b1, '0);
    b_set(1'b0, 1'b0, 1'b0, 1'b1, '0);
    b_set(1'b1, 1'b0, 1'b0, 1'b0, '0);
    repeat (10) @(posedge clk_a);
    @(negedge clk_b);
    chk(!b_rx_flag_n && !a_tx_flag_n, "R3 deselected read keeps mailbox full",
        {34'd0, b_rx_flag_n, a_tx_flag_n}, '0);
    b_get();

    // R9: stale reads racing with a refill
    fork
      begin
        repeat (4) b_set(1'b0, 1'b1, 1'b0, 1'b1, '0);
        b_set(1'b1, 1'b0, 1'b0, 1'b0, '0);
      end
      begin
        wait_a_tx_high(12, "R5 tx flag high before refill");
        a_put(36'h7_0000_0007);
      end
    join
    repeat (30) @(posedge clk_a);
    @(negedge clk_a);
    chk(!a_tx_flag_n, "R9 refill not cleared by stale reads", {35'd0, a_tx_flag_n}, '0);
    @(negedge clk_b);
    chk(!b_rx_flag_n, "R9 refill visible to reader", {35'd0, b_rx_flag_n}, '0);
    b_get();
    wait_a_tx_high(8, "R5 tx flag high after refill read");

    // R7: queue selection and write cycles on port B
    b_q_word = 36'h3_C3C3_C3C3;
    b_set(1'b0, 1'b1, 1'b0, 1'b0, '0);
    @(negedge clk_b);
    chk(b_dout_oe && b_dout == 36'h3_C3C3_C3C3, "R7 queue word on port B", b_dout, 36'h3_C3C3_C3C3);
    b_set(1'b0, 1'b0, 1'b1, 1'b0, '0);
    @(negedge clk_b);
    chk(!b_dout_oe && b_dout == '0, "R7 bus idle during write", b_dout, '0);
    b_set(1'b1, 1'b0, 1'b0, 1'b0, '0);

    // reverse direction: R1, R2, R4, R5, R6
    b_set(1'b0, 1'b1, 1'b1, 1'b1, 36'h9_8765_4321);
    b_set(1'b0, 1'b1, 1'b1, 1'b1, 36'h2_2222_2222);
    b_set(1'b1, 1'b0, 1'b0, 1'b0, '0);
    @(negedge clk_b);
    chk(!b_tx_flag_n, "R1 port B tx flag low", {35'd0, b_tx_flag_n}, '0);
    repeat (4) @(posedge clk_a);
    @(negedge clk_a);
    chk(!a_rx_flag_n, "R4 port A rx flag low", {35'd0, a_rx_flag_n}, '0);
    a_set(1'b0, 1'b1, 1'b0, 1'b1, '0);
    @(negedge clk_a);
    chk(a_dout == 36'h9_8765_4321, "R2 port A reads first word", a_dout, 36'h9_8765_4321);
    a_set(1'b0, 1'b1, 1'b0, 1'b1, '0);
    @(negedge clk_a);
    chk(a_rx_flag_n && a_dout == 36'h9_8765_4321, "R6 port A word kept", a_dout, 36'h9_8765_4321);
    a_q_word = 36'h6_0606_0606;
    a_set(1'b0, 1'b1, 1'b0, 1'b0, '0);
    @(negedge clk_a);
    chk(a_dout == 36'h6_0606_0606, "R7 queue word on port A", a_dout, 36'h6_0606_0606);
    a_set(1'b1, 1'b0, 1'b0, 1'b0, '0);
    repeat (12) @(posedge clk_b);
    @(negedge clk_b);
    chk(b_tx_flag_n, "R5 port B tx flag returns high", {35'd0, b_tx_flag_n}, 36'd1);

    chk(exp_q.size() == 0, "R1 every accepted word delivered", exp_q.size(), '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_a);
        chk(1'b0, "R1 watchdog expired", '0, 36'd1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule